// File: doc/BRIEF.md
# Half-Precision to Signed Integer Converter

The block turns one IEEE half-precision number into a signed integer, either 32 or 64 bits wide. The number is taken from the lowest 16-bit lane of a wider vector operand, and the other lanes play no part. The value is rounded with one of four rounding modes. The mode is normally taken from a global control field. A per-operation embedded field replaces it, but only when the source is a register and the override bit is set.

The block reports an inexact result and an invalid conversion. Infinities and NaNs are always invalid, and so is any value that does not fit the destination width after rounding. When invalid is masked, the block writes the most negative integer of the destination width. When invalid is unmasked, the block raises a fault and writes nothing.

Each accepted request produces one registered result one clock later. A write enable marks the results that may be committed to the destination register.

Top module: `hcv_top`

## Requirements
- R1: Only bits [15:0] of `src_vec` are converted: bit 15 is the sign, bits [14:10] the biased exponent (bias 15) and bits [9:0] the fraction. Bits above 15 have no effect on any output.
- R2: The result is 64 bits wide (`result_wide`=1) only when `long_mode`=1 and `wide_op`=1. Otherwise the result is 32 bits wide, carried in `result[31:0]`, with `result[63:32]` zero.
- R3: When `long_mode`=0, `wide_op` has no effect on any output.
- R4: The rounding mode is `emb_rc` when `src_is_reg`=1 and `rc_override`=1, and `glob_rc` in every other case.
- R5: The rounding-mode encoding is 00 nearest with ties to even, 01 toward negative infinity, 10 toward positive infinity, and 11 toward zero. An exactly representable value converts without change.
- R6: `flag_inexact` is 1 exactly when the input is finite, its value is not an integer, and the conversion is not invalid.
- R7: An exponent field of all ones (an infinity or a NaN) raises `flag_invalid`, and `flag_inexact` is then 0.
- R8: If a conversion is invalid and `inv_mask`=1, the result is the indefinite value: 0x80000000 for a 32-bit destination and 0x8000000000000000 for a 64-bit destination. `fault` is 0 and `wr_en` is 1.
- R9: If a conversion is invalid and `inv_mask`=0, `fault`=1, `wr_en`=0 and `result` is 0.
- R10: `out_valid` is 1 in the cycle after each cycle with `in_valid`=1, and 0 otherwise. `wr_en` equals `out_valid` whenever `fault`=0.
- R11: While reset is applied and right after it is released, `out_valid`, `wr_en`, `fault`, `flag_invalid` and `flag_inexact` are 0.
- R12: Zero and subnormal inputs convert to 0, +1 or -1 according to the rounding mode. Negative zero converts to 0 and is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A request is present this cycle |
| src_vec | input | VEC_W (128) | Vector source; only the lowest half-precision lane is used |
| glob_rc | input | 2 | Global rounding-control field |
| emb_rc | input | 2 | Embedded per-operation rounding field |
| rc_override | input | 1 | Request to use the embedded rounding field |
| src_is_reg | input | 1 | Source operand is a register |
| long_mode | input | 1 | 64-bit mode is active |
| wide_op | input | 1 | 64-bit destination requested |
| inv_mask | input | 1 | Invalid exception is masked |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Converted integer |
| result_wide | output | 1 | Result is 64 bits wide |
| flag_invalid | output | 1 | Invalid conversion |
| flag_inexact | output | 1 | Precision lost in rounding |
| fault | output | 1 | Unmasked invalid; result not written |
| wr_en | output | 1 | Result may be written to the destination |

## Verification
The assertions assume the control inputs are valid in every cycle in which `in_valid` is high. They also assume that `in_valid` low leaves the previous request's inputs free to change without effect. The bench changes all inputs only on falling edges and holds each request for exactly one cycle.

The properties relate the registered outputs to the inputs of the previous cycle. The bench therefore runs requests back to back and also separated by idle cycles, so that both cases reach the latency and no-spurious-output checks. Upper vector lanes and unused controls are filled with random values, which keeps the "ignored" properties from being met by a constant.

// File: rtl/hcv_pkg.sv
package hcv_pkg;

  localparam int HALF_W = 16;
  localparam int EXP_W  = 5;
  localparam int MAN_W  = 10;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  // fixed-point fraction bits so the smallest subnormal lands on an integer
  localparam int FRAC_W = BIAS + MAN_W - 1;
  // widest shifted significand: largest finite exponent minus one
  localparam int FX_W   = MAN_W + 1 + ((1 << EXP_W) - 3);
  localparam int IPART_W = FX_W - FRAC_W;
  localparam int MAG_W  = IPART_W + 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             neg;
    logic             special;
    logic             lossy;
    logic [MAG_W-1:0] mag;
  } conv_t;

  // decides whether the truncated magnitude must be bumped by one
  function automatic logic need_inc(rmode_e rm, logic neg, logic lsb,
                                    logic half, logic sticky);
    logic any;
    any = half | sticky;
    case (rm)
      RM_NEAR: need_inc = half & (sticky | lsb);
      RM_DOWN: need_inc = neg & any;
      RM_UP:   need_inc = ~neg & any;
      default: need_inc = 1'b0;
    endcase
  endfunction

  // shift amount that places the significand on the fixed-point grid
  function automatic logic [EXP_W-1:0] grid_shift(logic [EXP_W-1:0] ex);
    grid_shift = (ex == '0) ? '0 : ex - EXP_W'(1);
  endfunction

endpackage

// File: rtl/hcv_mode_sel.sv
module hcv_mode_sel
  import hcv_pkg::*;
(
  input  logic [1:0] glob_rc,
  input  logic [1:0] emb_rc,
  input  logic       rc_override,
  input  logic       src_is_reg,
  output rmode_e     rm
);

  logic use_emb;
  assign use_emb = src_is_reg & rc_override;
  assign rm      = use_emb ? rmode_e'(emb_rc) : rmode_e'(glob_rc);

endmodule

// File: rtl/hcv_unpack_round.sv
module hcv_unpack_round
  import hcv_pkg::*;
(
  input  logic [HALF_W-1:0] half_in,
  input  rmode_e            rm,
  output conv_t             cv
);

  logic [EXP_W-1:0]   ex;
  logic [MAN_W-1:0]   man;
  logic [MAN_W:0]     sig;
  logic [FX_W-1:0]    fx;
  logic [IPART_W-1:0] ipart;
  logic [FRAC_W-1:0]  frac;
  logic               half_bit;
  logic               sticky;
  logic               inc;

  assign ex       = half_in[HALF_W-2 -: EXP_W];
  assign man      = half_in[MAN_W-1:0];
  assign sig      = {|ex, man};
  assign fx       = FX_W'(sig) << grid_shift(ex);
  assign ipart    = fx[FX_W-1:FRAC_W];
  assign frac     = fx[FRAC_W-1:0];
  assign half_bit = frac[FRAC_W-1];
  assign sticky   = |frac[FRAC_W-2:0];
  assign inc      = need_inc(rm, half_in[HALF_W-1], ipart[0], half_bit, sticky);

  always_comb begin
    cv.neg     = half_in[HALF_W-1];
    cv.special = &ex;
    cv.lossy   = half_bit | sticky;
    cv.mag     = MAG_W'(ipart) + MAG_W'(inc);
  end

endmodule

// File: rtl/hcv_range_pack.sv
module hcv_range_pack
  import hcv_pkg::*;
#(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  conv_t             cv,
  input  logic              wide,
  input  logic              inv_mask,
  output logic [INT_W-1:0]  res,
  output logic              invalid,
  output logic              inexact,
  output logic              flt
);

  localparam int EXT_W = INT_W + 1;

  logic [EXT_W-1:0] mag_x;
  logic [EXT_W-1:0] lim;
  logic             over;
  logic [INT_W-1:0] sval;
  logic [INT_W-1:0] indef;

  assign mag_x   = EXT_W'(cv.mag);
  assign lim     = wide ? (EXT_W'(1) << (INT_W - 1)) : (EXT_W'(1) << (NARROW_W - 1));
  assign over    = cv.neg ? (mag_x > lim) : (mag_x >= lim);
  assign sval    = cv.neg ? (~mag_x[INT_W-1:0] + INT_W'(1)) : mag_x[INT_W-1:0];
  assign indef   = wide ? (INT_W'(1) << (INT_W - 1)) : (INT_W'(1) << (NARROW_W - 1));
  assign invalid = cv.special | over;
  assign inexact = cv.lossy & ~invalid;
  assign flt     = invalid & ~inv_mask;

  always_comb begin
    if (flt)          res = '0;
    else if (invalid) res = indef;
    else if (wide)    res = sval;
    else              res = INT_W'(sval[NARROW_W-1:0]);
  end

endmodule

// File: rtl/hcv_top.sv
module hcv_top
  import hcv_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [1:0]       glob_rc,
  input  logic [1:0]       emb_rc,
  input  logic             rc_override,
  input  logic             src_is_reg,
  input  logic             long_mode,
  input  logic             wide_op,
  input  logic             inv_mask,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             result_wide,
  output logic             flag_invalid,
  output logic             flag_inexact,
  output logic             fault,
  output logic             wr_en
);

  rmode_e           rm_sel;
  conv_t            cv;
  logic             wide_sel;
  logic [INT_W-1:0] res_c;
  logic             inv_c;
  logic             inx_c;
  logic             flt_c;
  logic             unused_lanes;

  assign unused_lanes = ^src_vec[VEC_W-1:HALF_W];
  assign wide_sel     = long_mode & wide_op;

  hcv_mode_sel u_mode (
    .glob_rc     (glob_rc),
    .emb_rc      (emb_rc),
    .rc_override (rc_override),
    .src_is_reg  (src_is_reg),
    .rm          (rm_sel)
  );

  hcv_unpack_round u_conv (
    .half_in (src_vec[HALF_W-1:0]),
    .rm      (rm_sel),
    .cv      (cv)
  );

  hcv_range_pack #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_pack (
    .cv       (cv),
    .wide     (wide_sel),
    .inv_mask (inv_mask),
    .res      (res_c),
    .invalid  (inv_c),
    .inexact  (inx_c),
    .flt      (flt_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      result_wide  <= 1'b0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      fault        <= 1'b0;
      wr_en        <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & ~flt_c;
      if (in_valid) begin
        result       <= res_c;
        result_wide  <= wide_sel;
        flag_invalid <= inv_c;
        flag_inexact <= inx_c;
        fault        <= flt_c;
      end else begin
        flag_invalid <= 1'b0;
        flag_inexact <= 1'b0;
        fault        <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hcv_checks.sv
module hcv_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        src_is_reg,
  input logic        rc_override,
  input logic [1:0]  glob_rc,
  input logic [1:0]  emb_rc,
  input logic        long_mode,
  input logic        inv_mask,
  input logic [1:0]  rm_sel,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        result_wide,
  input logic        flag_invalid,
  input logic        flag_inexact,
  input logic        fault,
  input logic        wr_en
);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fault) |-> wr_en);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_invalid && flag_inexact));

  a_r9_fault_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!wr_en && result == 64'd0 && flag_invalid));

  a_r8_masked_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inv_mask) |=> !fault);

  a_r2_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !result_wide) |-> result[63:32] == 32'd0);

  a_r3_short_mode_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !long_mode) |=> !result_wide);

  a_r4_global_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_is_reg || !rc_override) |-> rm_sel == glob_rc);

  a_r4_embedded_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (src_is_reg && rc_override) |-> rm_sel == emb_rc);

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_en && !fault && !flag_invalid && !flag_inexact));

endmodule

bind hcv_top hcv_checks u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .src_is_reg   (src_is_reg),
  .rc_override  (rc_override),
  .glob_rc      (glob_rc),
  .emb_rc       (emb_rc),
  .long_mode    (long_mode),
  .inv_mask     (inv_mask),
  .rm_sel       (rm_sel),
  .out_valid    (out_valid),
  .result       (result),
  .result_wide  (result_wide),
  .flag_invalid (flag_invalid),
  .flag_inexact (flag_inexact),
  .fault        (fault),
  .wr_en        (wr_en)
);

// File: tb/hcv_top_test.sv
`timescale 1ns/1ps
module hcv_top_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0;
  logic [1:0]   glob_rc = 2'b00;
  logic [1:0]   emb_rc = 2'b00;
  logic         rc_override = 1'b0;
  logic         src_is_reg = 1'b0;
  logic         long_mode = 1'b0;
  logic         wide_op = 1'b0;
  logic         inv_mask = 1'b1;
  logic         out_valid;
  logic [63:0]  result;
  logic         result_wide;
  logic         flag_invalid;
  logic         flag_inexact;
  logic         fault;
  logic         wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] res;
    logic        wide;
    logic        inv;
    logic        inx;
    logic        flt;
    logic        wr;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  hcv_top uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .src_vec (src_vec),
    .glob_rc (glob_rc), .emb_rc (emb_rc), .rc_override (rc_override),
    .src_is_reg (src_is_reg), .long_mode (long_mode), .wide_op (wide_op),
    .inv_mask (inv_mask), .out_valid (out_valid), .result (result),
    .result_wide (result_wide), .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact), .fault (fault), .wr_en (wr_en)
  );

  // reference model built on real arithmetic, independent of the bit-level design
  function automatic exp_t model(logic [15:0] h, logic [1:0] rm, logic wide,
                                 logic mask, string tag);
    exp_t x;
    real v, fl, ce, pick;
    int e, p;
    longint iv;
    logic inv;
    inv = 1'b0;
    x.inx = 1'b0;
    iv = 0;
    e = int'(h[14:10]);
    if (e == 31) inv = 1'b1;
    else begin
      v = (e == 0) ? real'(h[9:0]) : real'(1024 + int'(h[9:0]));
      p = ((e == 0) ? 1 : e) - 25;
      if (p >= 0) repeat (p) v = v * 2.0;
      else repeat (-p) v = v / 2.0;
      if (h[15]) v = -v;
      fl = $floor(v);
      ce = $ceil(v);
      case (rm)
        2'b00: begin
          if (v - fl < 0.5) pick = fl;
          else if (v - fl > 0.5) pick = ce;
          else pick = (($rtoi(fl) % 2) == 0) ? fl : ce;
        end
        2'b01: pick = fl;
        2'b10: pick = ce;
        default: pick = (v < 0.0) ? ce : fl;
      endcase
      iv = longint'($rtoi(pick));
      x.inx = (pick != v);
      if (!wide && (iv < -64'sd2147483648 || iv > 64'sd2147483647)) inv = 1'b1;
    end
    x.inv = inv;
    x.wide = wide;
    x.tag = tag;
    if (inv) begin
      x.inx = 1'b0;
      x.flt = !mask;
      x.wr = mask;
      x.res = !mask ? 64'd0 : (wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000);
    end else begin
      x.flt = 1'b0;
      x.wr = 1'b1;
      x.res = wide ? iv : {32'd0, iv[31:0]};
    end
    return x;
  endfunction

  task automatic send(input logic [15:0] h, input logic [1:0] g, input logic [1:0] emb,
                      input logic ovr, input logic isreg, input logic lm,
                      input logic wop, input logic msk, input string tag);
    logic [1:0] rm;
    @(negedge clk);
    rm = (isreg && ovr) ? emb : g;
    in_valid    = 1'b1;
    src_vec     = {$urandom(), $urandom(), $urandom(), $urandom()};
    src_vec[15:0] = h;
    glob_rc     = g;
    emb_rc      = emb;
    rc_override = ovr;
    src_is_reg  = isreg;
    long_mode   = lm;
    wide_op     = wop;
    inv_mask    = msk;
    sb.push_back(model(h, rm, lm & wop, msk, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_vec  = {$urandom(), $urandom(), $urandom(), $urandom()};
    end
  endtask

  task automatic fail_line(input string what, input logic [63:0] act, input logic [63:0] ex);
    errors++;
    $display("FAIL %s actual=%h expected=%h", what, act, ex);
  endtask

  // monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      checks++;
      if (sb.size() == 0) fail_line("R10 output without request", 64'd1, 64'd0);
      else begin
        exp_t x;
        x = sb.pop_front();
        if (result !== x.res)            fail_line({x.tag, " result"}, result, x.res);
        else if (result_wide !== x.wide) fail_line({x.tag, " width"}, 64'(result_wide), 64'(x.wide));
        else if (flag_invalid !== x.inv) fail_line({x.tag, " invalid"}, 64'(flag_invalid), 64'(x.inv));
        else if (flag_inexact !== x.inx) fail_line({x.tag, " inexact"}, 64'(flag_inexact), 64'(x.inx));
        else if (fault !== x.flt)        fail_line({x.tag, " fault"}, 64'(fault), 64'(x.flt));
        else if (wr_en !== x.wr)         fail_line({x.tag, " wr_en"}, 64'(wr_en), 64'(x.wr));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || fault !== 1'b0 ||
        flag_invalid !== 1'b0 || flag_inexact !== 1'b0)
      fail_line("R11 reset state", {59'd0, out_valid, wr_en, fault, flag_invalid, flag_inexact}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0)
      fail_line("R11 after release", {62'd0, out_valid, wr_en}, 64'd0);

    // R5 exact values and each rounding mode on halfway points
    send(16'h3C00, 2'b00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 one");
    send(16'h7BFF, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R5 max 64");
    send(16'hFBFF, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R5 min 64");
    for (int m = 0; m < 4; m++) begin
      send(16'h4100, 2'(m), 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 R6 +2.5");
      send(16'hC100, 2'(m), 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 R6 -2.5");
      send(16'h3E00, 2'(m), 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 R6 +1.5");
      send(16'h3800, 2'(m), 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 R6 +0.5");
    end
    idle(2);
    // R12 zero and subnormals
    for (int m = 0; m < 4; m++) begin
      send(16'h8000, 2'(m), 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R12 negative zero");
      send(16'h0001, 2'(m), 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R12 +tiny");
      send(16'h8001, 2'(m), 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R12 -tiny 64");
      send(16'h83FF, 2'(m), 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R12 -subnormal 32");
    end
    // R4 embedded field used only for register source with override
    send(16'h4100, 2'b00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4 embedded up");
    send(16'h4100, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 memory source");
    send(16'h4100, 2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4 no override");
    // R1 upper lanes random, same low lane
    send(16'hC555, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1 lane a");
    send(16'hC555, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1 lane b");
    // R2 R3 width selection
    send(16'hC000, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 short mode wide bit");
    send(16'hC000, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R2 long narrow");
    send(16'hC000, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R2 long wide");
    idle(1);
    // R7 R8 R9 special inputs
    send(16'h7C00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 R8 +inf 32");
    send(16'hFC00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R7 R8 -inf 64");
    send(16'h7E00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 R8 nan");
    send(16'h7C00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 inf unmasked");
    send(16'hFE01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9 nan unmasked 64");
    send(16'h3C00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 after fault");
    idle(3);
    // R6 R5 random sweep with random gaps
    for (int i = 0; i < 600; i++) begin
      send(16'($urandom()), 2'($urandom()), 2'($urandom()), 1'($urandom()),
           1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
           "R5 R6 R7 sweep");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (sb.size() != 0) fail_line("R10 results missing", 64'(sb.size()), 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule